// File: doc/BRIEF.md
# Token-Stream Triple-Redundancy Splitter and Majority Voter

This block protects a streaming computation by running it three times. On the way in, a splitter takes each token from one valid/ready source and offers an identical copy on three replica output streams. On the way back, a voter collects one result token from each of three replica input streams, chooses the value that at least two of them agree on, and sends it downstream on one valid/ready stream.

Every handshake blocks. The splitter does not take a new token until all three copies of the previous one have left, so the replicas never drift apart by more than one token. The voter takes nothing more from a replica that has already delivered its token until the current vote is finished and its result has left. When exactly one replica disagrees, the voter issues a one-cycle fault pulse that carries that replica's index. It also keeps a saturating mismatch count for each replica. When all three tokens differ, the voter issues a split pulse. A configuration input then decides whether the voter forwards replica 0's token or sends nothing for that vote.

Top module: `tmr_guard`

## Requirements
- R1: Each token accepted on the source stream appears unchanged on all three replica output streams. Each copy's valid stays high until the ready of that same replica has been seen at a clock edge.
- R2: `src_ready` is high exactly when no copy of the previous token is still pending. A new token is therefore accepted only after all three copies have been taken.
- R3: A vote uses exactly one token from each replica input. A replica that has delivered its token sees its ready held low until the vote completes. No output appears before all three tokens are present, and an output appears one clock edge after the third token is taken.
- R4: When all three tokens are equal, `dst_data` carries that value, and neither `fault_pulse` nor `split_pulse` is raised.
- R5: When exactly two tokens agree, `dst_data` carries the agreed value. For one cycle, in the same cycle that the result first becomes valid, `fault_pulse` is high and `fault_replica` holds the index of the disagreeing replica. The index is 0, 1 or 2, in the order of the replica port slices.
- R6: When all three tokens differ, `split_pulse` is high for one cycle and no fault is attributed. If `hold_on_split` is 0, replica 0's token is forwarded. If it is 1, nothing is sent for that vote and the voter is free to take the next tokens.
- R7: Once `dst_valid` rises, it and `dst_data` stay unchanged until `dst_ready` is seen. During that time all replica input readys stay low.
- R8: Each replica has a mismatch count of `CNT_W` bits in `mism_count` (replica i at bits i*CNT_W and up). The count rises by one, one cycle after each fault pulse naming that replica, and saturates at 2^CNT_W-1. Split votes do not change any count.
- R9: After reset, `src_ready` is high, all replica input readys are high, and no valid, pulse or count is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_on_split | input | 1 | 1: send nothing when all three tokens differ; 0: forward replica 0 |
| src_valid | input | 1 | Source token valid |
| src_ready | output | 1 | Splitter can take a token |
| src_data | input | DATA_W | Source token |
| rep_tx_valid | output | 3 | Copy pending, one bit per replica |
| rep_tx_ready | input | 3 | Replica takes its copy |
| rep_tx_data | output | 3*DATA_W | Copies, replica i at slice i |
| rep_rx_valid | input | 3 | Replica result valid |
| rep_rx_ready | output | 3 | Voter can take a result from replica i |
| rep_rx_data | input | 3*DATA_W | Replica results, replica i at slice i |
| dst_valid | output | 1 | Voted result valid |
| dst_ready | input | 1 | Downstream takes the result |
| dst_data | output | DATA_W | Voted result |
| fault_pulse | output | 1 | One-cycle single-replica disagreement |
| fault_replica | output | 2 | Index of the disagreeing replica |
| split_pulse | output | 1 | One-cycle three-way disagreement |
| mism_count | output | 3*CNT_W | Saturating mismatch count per replica |

## Verification
The bench drives each way a vote can end: all three agree, each replica in turn is the odd one out, and a three-way split under both settings of the configuration bit. A voter that chose the wrong replica's token or reported the wrong index would put a wrong value on `dst_data` or `fault_replica`. A voter that mishandled a split would either send an output that should have been withheld or send nothing when replica 0's token should have been forwarded. The bench also lets replicas arrive at different times and holds back every ready. A voter that fired early or took a second token while busy would produce an output too soon or show a ready high where it must be low. A splitter that accepted new data while a copy was still pending would show `src_ready` high too soon. Finally, one replica is made to fail enough times to drive its count to the ceiling, where a counter without saturation would wrap to zero.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned LANES = 3;

    typedef enum logic [1:0] {
        VERDICT_AGREE  = 2'd0,
        VERDICT_SINGLE = 2'd1,
        VERDICT_SPLIT  = 2'd2
    } verdict_e;

    typedef struct packed {
        verdict_e   verdict;
        logic [1:0] odd_idx;
        logic [1:0] pick;
    } vote_t;

    // Classifies a vote from the three pairwise equality results.
    function automatic vote_t classify(input logic eq01, input logic eq02, input logic eq12);
        vote_t v;
        v.verdict = VERDICT_SPLIT;
        v.odd_idx = 2'd0;
        v.pick    = 2'd0;
        if (eq01 && eq02) begin
            v.verdict = VERDICT_AGREE;
        end else if (eq01) begin
            v.verdict = VERDICT_SINGLE;
            v.odd_idx = 2'd2;
        end else if (eq02) begin
            v.verdict = VERDICT_SINGLE;
            v.odd_idx = 2'd1;
        end else if (eq12) begin
            v.verdict = VERDICT_SINGLE;
            v.odd_idx = 2'd0;
            v.pick    = 2'd1;
        end
        return v;
    endfunction

endpackage

// File: rtl/tmr_fork.sv
module tmr_fork #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic [2:0]        out_valid,
    input  logic [2:0]        out_ready,
    output logic [DATA_W-1:0] out_data
);
    logic [2:0]        pending_q;
    logic [DATA_W-1:0] token_q;

    assign in_ready  = (pending_q == 3'b000);
    assign out_valid = pending_q;
    assign out_data  = token_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= 3'b000;
            token_q   <= '0;
        end else if (in_valid && in_ready) begin
            pending_q <= 3'b111;
            token_q   <= in_data;
        end else begin
            pending_q <= pending_q & ~out_ready;
        end
    end
endmodule

// File: rtl/tmr_slot.sv
module tmr_slot #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              block,
    input  logic              release_slot,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    logic              full_q;
    logic [DATA_W-1:0] data_q;

    assign in_ready = !full_q && !block;
    assign full     = full_q;
    assign data     = data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (release_slot) begin
            full_q <= 1'b0;
        end else if (in_valid && in_ready) begin
            full_q <= 1'b1;
            data_q <= in_data;
        end
    end
endmodule

// File: rtl/tmr_voter.sv
module tmr_voter
    import tmr_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hold_on_split,
    input  logic [2:0]          in_valid,
    output logic [2:0]          in_ready,
    input  logic [3*DATA_W-1:0] in_data,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [DATA_W-1:0]   out_data,
    output logic                fault,
    output logic [1:0]          fault_idx,
    output logic                split
);
    logic [2:0]        full;
    logic [DATA_W-1:0] slot_data [LANES];
    logic              decide;
    logic              out_valid_q;
    logic [DATA_W-1:0] out_data_q;
    logic              fault_q;
    logic [1:0]        fault_idx_q;
    logic              split_q;
    vote_t             vote;
    logic [DATA_W-1:0] chosen;

    assign decide = (&full) && !out_valid_q;

    for (genvar i = 0; i < LANES; i++) begin : g_slot
        tmr_slot #(.DATA_W(DATA_W)) slot_i (
            .clk          (clk),
            .rst          (rst),
            .in_valid     (in_valid[i]),
            .in_ready     (in_ready[i]),
            .in_data      (in_data[i*DATA_W +: DATA_W]),
            .block        (out_valid_q),
            .release_slot (decide),
            .full         (full[i]),
            .data         (slot_data[i])
        );
    end

    always_comb begin
        vote = classify(slot_data[0] == slot_data[1],
                        slot_data[0] == slot_data[2],
                        slot_data[1] == slot_data[2]);
        case (vote.pick)
            2'd1:    chosen = slot_data[1];
            2'd2:    chosen = slot_data[2];
            default: chosen = slot_data[0];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_q <= 1'b0;
            out_data_q  <= '0;
            fault_q     <= 1'b0;
            fault_idx_q <= 2'd0;
            split_q     <= 1'b0;
        end else begin
            fault_q <= decide && (vote.verdict == VERDICT_SINGLE);
            split_q <= decide && (vote.verdict == VERDICT_SPLIT);
            if (decide && (vote.verdict == VERDICT_SINGLE)) begin
                fault_idx_q <= vote.odd_idx;
            end
            if (decide && !((vote.verdict == VERDICT_SPLIT) && hold_on_split)) begin
                out_valid_q <= 1'b1;
                out_data_q  <= chosen;
            end else if (out_ready) begin
                out_valid_q <= 1'b0;
            end
        end
    end

    assign out_valid = out_valid_q;
    assign out_data  = out_data_q;
    assign fault     = fault_q;
    assign fault_idx = fault_idx_q;
    assign split     = split_q;
endmodule

// File: rtl/tmr_fault_tally.sv
module tmr_fault_tally
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 hit,
    input  logic [1:0]           hit_idx,
    output logic [3*CNT_W-1:0]   counts
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    for (genvar i = 0; i < LANES; i++) begin : g_cnt
        logic [CNT_W-1:0] cnt_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q <= '0;
            end else if (hit && (hit_idx == 2'(i)) && (cnt_q != CNT_MAX)) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
        assign counts[i*CNT_W +: CNT_W] = cnt_q;
    end
endmodule

// File: rtl/tmr_guard.sv
module tmr_guard #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CNT_W  = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hold_on_split,
    input  logic                src_valid,
    output logic                src_ready,
    input  logic [DATA_W-1:0]   src_data,
    output logic [2:0]          rep_tx_valid,
    input  logic [2:0]          rep_tx_ready,
    output logic [3*DATA_W-1:0] rep_tx_data,
    input  logic [2:0]          rep_rx_valid,
    output logic [2:0]          rep_rx_ready,
    input  logic [3*DATA_W-1:0] rep_rx_data,
    output logic                dst_valid,
    input  logic                dst_ready,
    output logic [DATA_W-1:0]   dst_data,
    output logic                fault_pulse,
    output logic [1:0]          fault_replica,
    output logic                split_pulse,
    output logic [3*CNT_W-1:0]  mism_count
);
    logic [DATA_W-1:0] copy_data;

    tmr_fork #(.DATA_W(DATA_W)) fork_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (src_valid),
        .in_ready  (src_ready),
        .in_data   (src_data),
        .out_valid (rep_tx_valid),
        .out_ready (rep_tx_ready),
        .out_data  (copy_data)
    );

    assign rep_tx_data = {3{copy_data}};

    tmr_voter #(.DATA_W(DATA_W)) voter_i (
        .clk           (clk),
        .rst           (rst),
        .hold_on_split (hold_on_split),
        .in_valid      (rep_rx_valid),
        .in_ready      (rep_rx_ready),
        .in_data       (rep_rx_data),
        .out_valid     (dst_valid),
        .out_ready     (dst_ready),
        .out_data      (dst_data),
        .fault         (fault_pulse),
        .fault_idx     (fault_replica),
        .split         (split_pulse)
    );

    tmr_fault_tally #(.CNT_W(CNT_W)) tally_i (
        .clk     (clk),
        .rst     (rst),
        .hit     (fault_pulse),
        .hit_idx (fault_replica),
        .counts  (mism_count)
    );
endmodule

// File: rtl/tmr_guard_chk.sv
module tmr_guard_chk #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CNT_W  = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               src_ready,
    input logic [2:0]         rep_tx_valid,
    input logic [2:0]         rep_tx_ready,
    input logic [2:0]         rep_rx_ready,
    input logic               dst_valid,
    input logic               dst_ready,
    input logic [DATA_W-1:0]  dst_data,
    input logic               fault_pulse,
    input logic               split_pulse,
    input logic [3*CNT_W-1:0] mism_count
);
    p_fork_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (|rep_tx_valid) |-> !src_ready);

    p_copy_kept_r1: assert property (@(posedge clk) disable iff (rst)
        ((rep_tx_valid & ~rep_tx_ready) != 3'b000)
        |=> (($past(rep_tx_valid & ~rep_tx_ready) & ~rep_tx_valid) == 3'b000));

    p_output_held_r7: assert property (@(posedge clk) disable iff (rst)
        (dst_valid && !dst_ready) |=> (dst_valid && $stable(dst_data)));

    p_no_intake_r7: assert property (@(posedge clk) disable iff (rst)
        dst_valid |-> (rep_rx_ready == 3'b000));

    p_fault_once_r5: assert property (@(posedge clk) disable iff (rst)
        fault_pulse |=> !fault_pulse);

    p_split_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(fault_pulse && split_pulse));

    for (genvar i = 0; i < 3; i++) begin : g_mono
        p_count_mono_r8: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (mism_count[i*CNT_W +: CNT_W] >= $past(mism_count[i*CNT_W +: CNT_W])));
    end
endmodule

bind tmr_guard tmr_guard_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .src_ready    (src_ready),
    .rep_tx_valid (rep_tx_valid),
    .rep_tx_ready (rep_tx_ready),
    .rep_rx_ready (rep_rx_ready),
    .dst_valid    (dst_valid),
    .dst_ready    (dst_ready),
    .dst_data     (dst_data),
    .fault_pulse  (fault_pulse),
    .split_pulse  (split_pulse),
    .mism_count   (mism_count)
);

// File: tb/tmr_guard_tb_top.sv
`timescale 1ns/1ps
module tmr_guard_tb_top;
    localparam int W  = 16;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          hold_on_split = 1'b0;
    logic          src_valid = 1'b0;
    logic          src_ready;
    logic [W-1:0]  src_data = '0;
    logic [2:0]    rep_tx_valid;
    logic [2:0]    rep_tx_ready = 3'b000;
    logic [3*W-1:0] rep_tx_data;
    logic [2:0]    rep_rx_valid = 3'b000;
    logic [2:0]    rep_rx_ready;
    logic [3*W-1:0] rep_rx_data = '0;
    logic          dst_valid;
    logic          dst_ready = 1'b0;
    logic [W-1:0]  dst_data;
    logic          fault_pulse;
    logic [1:0]    fault_replica;
    logic          split_pulse;
    logic [3*CW-1:0] mism_count;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    int exp_cnt [3] = '{0, 0, 0};

    always #2 clk = ~clk;

    tmr_guard #(.DATA_W(W), .CNT_W(CW)) dut_i (.*);

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic check_counts(input string tag);
        for (int i = 0; i < 3; i++) begin
            check(mism_count[i*CW +: CW] == exp_cnt[i], tag,
                  32'(mism_count[i*CW +: CW]), 32'(exp_cnt[i]));
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(src_ready == 1'b1, "R9 src_ready", 32'(src_ready), 1);
        check(rep_tx_valid == 3'b000, "R9 tx_valid", 32'(rep_tx_valid), 0);
        check(rep_rx_ready == 3'b111, "R9 rx_ready", 32'(rep_rx_ready), 7);
        check(dst_valid == 1'b0, "R9 dst_valid", 32'(dst_valid), 0);
        check(fault_pulse == 1'b0 && split_pulse == 1'b0, "R9 pulses",
              32'({fault_pulse, split_pulse}), 0);
        check_counts("R9 counts");
    endtask

    task automatic t_fork;
        @(negedge clk);
        src_valid = 1'b1; src_data = 16'hA5C3; rep_tx_ready = 3'b000;
        @(negedge clk);
        src_valid = 1'b1; src_data = 16'h1234;
        check(rep_tx_valid == 3'b111, "R1 all copies", 32'(rep_tx_valid), 7);
        for (int i = 0; i < 3; i++)
            check(rep_tx_data[i*W +: W] == 16'hA5C3, "R1 copy data", 32'(rep_tx_data[i*W +: W]), 32'hA5C3);
        check(src_ready == 1'b0, "R2 busy", 32'(src_ready), 0);
        rep_tx_ready = 3'b001;
        @(negedge clk);
        rep_tx_ready = 3'b000;
        check(rep_tx_valid == 3'b110, "R1 partial take", 32'(rep_tx_valid), 6);
        check(src_ready == 1'b0, "R2 still busy", 32'(src_ready), 0);
        @(negedge clk);
        check(rep_tx_valid == 3'b110, "R1 copies kept", 32'(rep_tx_valid), 6);
        rep_tx_ready = 3'b110;
        @(negedge clk);
        rep_tx_ready = 3'b000;
        check(src_ready == 1'b1, "R2 free", 32'(src_ready), 1);
        check(rep_tx_valid == 3'b000, "R1 all taken", 32'(rep_tx_valid), 0);
        @(negedge clk);
        src_valid = 1'b0;
        check(rep_tx_data[W +: W] == 16'h1234, "R2 next token", 32'(rep_tx_data[W +: W]), 32'h1234);
        rep_tx_ready = 3'b111;
        @(negedge clk);
        rep_tx_ready = 3'b000;
        check(rep_tx_valid == 3'b000 && src_ready, "R2 drained", 32'(rep_tx_valid), 0);
    endtask

    task automatic run_vote(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c,
                            input bit hold, input bit exp_out, input logic [W-1:0] exp_d,
                            input bit exp_fault, input logic [1:0] exp_idx, input bit exp_split,
                            input string tag);
        @(negedge clk);
        hold_on_split = hold;
        rep_rx_valid  = 3'b111;
        rep_rx_data   = {c, b, a};
        @(negedge clk);
        rep_rx_valid = 3'b000;
        check(dst_valid == 1'b0, {tag, " R3 not yet"}, 32'(dst_valid), 0);
        check(rep_rx_ready == 3'b000, {tag, " R3 slots full"}, 32'(rep_rx_ready), 0);
        @(negedge clk);
        check(dst_valid == exp_out, {tag, " out valid"}, 32'(dst_valid), 32'(exp_out));
        if (exp_out)
            check(dst_data == exp_d, {tag, " out data"}, 32'(dst_data), 32'(exp_d));
        check(fault_pulse == exp_fault, {tag, " R5 fault"}, 32'(fault_pulse), 32'(exp_fault));
        if (exp_fault) begin
            check(fault_replica == exp_idx, {tag, " R5 index"}, 32'(fault_replica), 32'(exp_idx));
            if (exp_cnt[exp_idx] < 15) exp_cnt[exp_idx]++;
        end
        check(split_pulse == exp_split, {tag, " R6 split"}, 32'(split_pulse), 32'(exp_split));
        if (exp_out) begin
            @(negedge clk);
            check(dst_valid == 1'b1 && dst_data == exp_d, {tag, " R7 held"}, 32'(dst_data), 32'(exp_d));
            check(rep_rx_ready == 3'b000, {tag, " R7 no intake"}, 32'(rep_rx_ready), 0);
            check(fault_pulse == 1'b0, {tag, " R5 one cycle"}, 32'(fault_pulse), 0);
            dst_ready = 1'b1;
            @(negedge clk);
            dst_ready = 1'b0;
            check(dst_valid == 1'b0, {tag, " R7 taken"}, 32'(dst_valid), 0);
        end else begin
            @(negedge clk);
        end
        check(rep_rx_ready == 3'b111, {tag, " R3 ready again"}, 32'(rep_rx_ready), 7);
        check_counts({tag, " R8 counts"});
    endtask

    task automatic t_votes;
        run_vote(16'h0042, 16'h0042, 16'h0042, 0, 1, 16'h0042, 0, 0, 0, "R4 agree");
        run_vote(16'h0BAD, 16'h0777, 16'h0777, 0, 1, 16'h0777, 1, 0, 0, "R5 odd0");
        run_vote(16'h0777, 16'h0BAD, 16'h0777, 0, 1, 16'h0777, 1, 1, 0, "R5 odd1");
        run_vote(16'h0777, 16'h0BAD, 16'h0777, 0, 1, 16'h0777, 1, 1, 0, "R8 odd1 again");
        run_vote(16'h1111, 16'h1111, 16'hFFFF, 0, 1, 16'h1111, 1, 2, 0, "R5 odd2");
        run_vote(16'h0001, 16'h0002, 16'h0003, 0, 1, 16'h0001, 0, 0, 1, "R6 fwd");
        run_vote(16'h0001, 16'h0002, 16'h0003, 1, 0, 16'h0000, 0, 0, 1, "R6 hold");
    endtask

    task automatic t_stagger;
        @(negedge clk);
        rep_rx_valid = 3'b011;
        rep_rx_data  = {16'h5555, 16'h2222, 16'h2222};
        @(negedge clk);
        rep_rx_valid = 3'b000;
        check(rep_rx_ready == 3'b100, "R3 stagger ready", 32'(rep_rx_ready), 4);
        check(dst_valid == 1'b0, "R3 wait third", 32'(dst_valid), 0);
        rep_rx_valid = 3'b011;
        rep_rx_data  = {16'h5555, 16'h9999, 16'h9999};
        @(negedge clk);
        rep_rx_valid = 3'b000;
        check(dst_valid == 1'b0, "R3 no second take", 32'(dst_valid), 0);
        rep_rx_valid = 3'b100;
        rep_rx_data  = {16'h2222, 16'h9999, 16'h9999};
        @(negedge clk);
        rep_rx_valid = 3'b000;
        @(negedge clk);
        check(dst_valid == 1'b1 && dst_data == 16'h2222, "R3 first tokens used",
              32'(dst_data), 32'h2222);
        check(fault_pulse == 1'b0, "R3 stagger agree", 32'(fault_pulse), 0);
        dst_ready = 1'b1;
        @(negedge clk);
        dst_ready = 1'b0;
    endtask

    task automatic t_saturate;
        for (int k = 0; k < 16; k++)
            run_vote(16'hDEAD, 16'h0300, 16'h0300, 0, 1, 16'h0300, 1, 0, 0, "R8 saturate");
        check(mism_count[0 +: CW] == 4'hF, "R8 ceiling", 32'(mism_count[0 +: CW]), 15);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fork();
        t_votes();
        t_stagger();
        t_saturate();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule